// File: doc/BRIEF.md
# Serial Port Character Buffering, Status and Interrupt Unit

This block sits between a register bus and the bit engine of a serial port. It holds two 16-entry character queues. The transmit queue is filled by register writes and drained by the bit engine. The receive queue is filled by the bit engine and drained by register reads. Each received entry stores the data together with its parity and framing error marks. The block derives level flags from the two queue fill levels. It records receive overruns and detects a receiver that has gone idle with characters still waiting. It merges every flag that software has enabled into one interrupt line.

Software uses a small set of byte offsets:

| Offset | Use |
| --- | --- |
| 0x04 | Transmit character |
| 0x08 | Receive character |
| 0x10 | Interrupt enable mask |
| 0x14 | Status |
| 0x1C | Idle limit, in character periods |
| 0x20 | Transmit queue flush, on any write |
| 0x24 | Receive queue flush, on any write |

Read data is combinational from the current state. Side effects of a read, such as removing a receive entry, take place at the clock edge that ends the read strobe. The bit engine pulses a character-period tick for the idle counter. The baud generator and the serial shifter are outside this block.

Top module: `sio_fifo_irq`

## Requirements
- R1: After reset, status reads 0x006 (only transmit-empty bit1 and transmit-half-empty bit2 set), the interrupt is low, and a receive read returns 0.
- R2: Each queue holds 16 entries in first-in first-out order. A transmit write to a full queue is dropped, and status bit9 shows the transmit queue full.
- R3: Status bit1 is set when the transmit queue is empty. Bit6 is set when it holds at least one entry. Bit2 is set when it holds at most 8 entries, which leaves at least 8 free.
- R4: A receive read returns {frame error, parity error, data[7:0]} in bits 9, 8 and 7:0. Status bit3 and bit4 show the parity and frame marks of the entry at the head of the receive queue.
- R5: Status bit0 is set when the receive queue is not empty. Bit8 is set when it holds 8 or more entries.
- R6: A received character that arrives while the receive queue is full, with no read in the same cycle, is discarded and sets overrun status bit5. Any read that removes a receive entry clears bit5.
- R7: A read of the empty receive queue returns 0 and leaves the queue unchanged.
- R8: An idle counter restarts at each received character. It advances once per tick while the receive queue is non-empty. Timeout status bit7 sets on the tick that brings the counter to the limit at offset 0x1C. A receive read or a receive flush clears bit7.
- R9: Any write to offset 0x20 empties the transmit queue. Any write to offset 0x24 empties the receive queue and clears overrun and timeout.
- R10: The interrupt is the OR of status bits 8:0 ANDed with enable bits 8:0, which sit at the same positions. The enable mask reads back at offset 0x10.
- R11: An idle limit of 0 never raises the timeout flag.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| tx_pop | input | 1 | Bit engine takes the head transmit character |
| tx_data | output | 9 | Head transmit character |
| tx_avail | output | 1 | Transmit queue holds a character |
| rx_push | input | 1 | Bit engine delivers a received character |
| rx_word | input | 10 | Received {frame error, parity error, data} |
| rx_tick | input | 1 | One pulse per character period |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the transmit queue across the half mark and past full. A design with an off-by-one level compare would flip bit2 one entry early, and one that accepts a 17th write would corrupt the drain order. It overflows the receive queue and reads back. A design that overwrites on overrun, or that fails to clear bit5 on a read, would return the wrong head or leave the flag set. The idle timeout is tried at its exact limit, with a character arriving mid-count, and with a limit of zero. A counter that ignores the restart, or that fires one tick late or early, would show bit7 at the wrong time. Empty reads and both flush offsets are checked for stray pointer motion.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned STS_W  = 11;
  localparam int unsigned IEN_W  = 9;

  localparam logic [ADDR_W-1:0] OFS_TXCHR = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_RXCHR = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STS   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IDLE  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TXFL  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_RXFL  = 6'h24;

  localparam int unsigned B_RXNE  = 0;
  localparam int unsigned B_TXE   = 1;
  localparam int unsigned B_TXHE  = 2;
  localparam int unsigned B_PERR  = 3;
  localparam int unsigned B_FERR  = 4;
  localparam int unsigned B_OVR   = 5;
  localparam int unsigned B_TXNE  = 6;
  localparam int unsigned B_IDLE  = 7;
  localparam int unsigned B_RXHF  = 8;
  localparam int unsigned B_TXF   = 9;
  localparam int unsigned B_NACK  = 10;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
  assign rdata = mem[rd_q];

  always_comb begin
    do_pop  = pop && !empty && !flush;
    do_push = push && (!full || do_pop) && !flush;
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> cnt_q == CW'(DEPTH));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> cnt_q == '0);
endmodule

// File: rtl/sio_rx_idle.sv
module sio_rx_idle #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          tick,
  input  logic          active,
  input  logic [TW-1:0] limit,
  input  logic          clear,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          step;

  always_comb begin
    step   = active && tick && !reload && (cnt_q != limit);
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (reload)    cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    if (clear)
      flag_d = 1'b0;
    else if (step && (limit != '0) && (cnt_q + 1'b1 == limit))
      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign expired = flag_q;

  a_r8_set_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick) && $past(active));

  a_r11_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) && !flag_q |=> !flag_q);
endmodule

// File: rtl/sio_fifo_irq.sv
module sio_fifo_irq
  import sio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned TX_W   = 9,
  parameter int unsigned RX_W   = 10,
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              tx_pop,
  output logic [TX_W-1:0]   tx_data,
  output logic              tx_avail,
  input  logic              rx_push,
  input  logic [RX_W-1:0]   rx_word,
  input  logic              rx_tick,
  output logic              irq
);
  localparam int unsigned CW   = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [RX_W-1:0]   rx_head;
  logic              wr_tx, rd_rx, tx_flush, rx_flush, rx_take, ovf_ev;
  logic              idle_flag;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic [IDLE_W-1:0] lim_q, lim_d;
  logic              ovr_q, ovr_d;
  logic [STS_W-1:0]  sts;

  assign wr_tx    = reg_wr && (reg_addr == OFS_TXCHR);
  assign rd_rx    = reg_rd && (reg_addr == OFS_RXCHR);
  assign tx_flush = reg_wr && (reg_addr == OFS_TXFL);
  assign rx_flush = reg_wr && (reg_addr == OFS_RXFL);
  assign rx_take  = rd_rx && !rx_empty;
  assign ovf_ev   = rx_push && rx_full && !rx_take && !rx_flush;

  sio_fifo #(.WIDTH(TX_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(wr_tx), .wdata(reg_wdata[TX_W-1:0]),
    .pop(tx_pop), .rdata(tx_data), .count(tx_cnt),
    .empty(tx_empty), .full(tx_full)
  );

  sio_fifo #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .wdata(rx_word),
    .pop(rd_rx), .rdata(rx_head), .count(rx_cnt),
    .empty(rx_empty), .full(rx_full)
  );

  sio_rx_idle #(.TW(IDLE_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .reload(rx_push), .tick(rx_tick),
    .active(!rx_empty), .limit(lim_q),
    .clear(rx_take || rx_flush), .expired(idle_flag)
  );

  assign tx_avail = !tx_empty;

  always_comb begin
    sts         = '0;
    sts[B_RXNE] = !rx_empty;
    sts[B_TXE]  = tx_empty;
    sts[B_TXHE] = (tx_cnt <= HALF);
    sts[B_PERR] = !rx_empty && rx_head[8];
    sts[B_FERR] = !rx_empty && rx_head[9];
    sts[B_OVR]  = ovr_q;
    sts[B_TXNE] = !tx_empty;
    sts[B_IDLE] = idle_flag;
    sts[B_RXHF] = (rx_cnt >= HALF);
    sts[B_TXF]  = tx_full;
    sts[B_NACK] = 1'b0;
  end

  assign irq = |(sts[IEN_W-1:0] & ien_q);

  always_comb begin
    ien_d = ien_q;
    lim_d = lim_q;
    ovr_d = ovr_q;
    if (reg_wr && (reg_addr == OFS_IEN))  ien_d = reg_wdata[IEN_W-1:0];
    if (reg_wr && (reg_addr == OFS_IDLE)) lim_d = reg_wdata[IDLE_W-1:0];
    if (rx_flush)     ovr_d = 1'b0;
    else if (ovf_ev)  ovr_d = 1'b1;
    else if (rx_take) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      lim_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      ien_q <= ien_d;
      lim_q <= lim_d;
      ovr_q <= ovr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_RXCHR: reg_rdata = rx_empty ? '0 : BUS_W'(rx_head);
      OFS_IEN:   reg_rdata = BUS_W'(ien_q);
      OFS_STS:   reg_rdata = BUS_W'(sts);
      OFS_IDLE:  reg_rdata = BUS_W'(lim_q);
      default:   reg_rdata = '0;
    endcase
  end

  a_r6_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !rx_empty |=> !ovr_q);

  a_r6_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !rd_rx && !reg_wr |=> ovr_q);

  a_r9_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_cnt == '0);

  a_r9_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0) && !ovr_q && !idle_flag);

  a_r10_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/sio_fifo_irq_test.sv
module sio_fifo_irq_test;
  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        tx_pop, tx_avail, rx_push, rx_tick, irq;
  logic [8:0]  tx_data;
  logic [9:0]  rx_word;
  int          errors, checks;
  logic [15:0] v;

  sio_fifo_irq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
    .rx_push(rx_push), .rx_word(rx_word), .rx_tick(rx_tick), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic push(input logic [9:0] w);
    @(negedge clk); rx_push = 1'b1; rx_word = w;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_tick = 1'b1;
      @(negedge clk); rx_tick = 1'b0;
    end
  endtask

  function automatic logic [9:0] pat(input int i);
    return 10'((i * 71 + 'h2A5) & 'h3FF);
  endfunction

  task automatic t_reset();
    peek(6'h14, v); check("R1 status", v, 16'h0006);
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(6'h08, v); check("R1 rx read", v, 16'd0);
  endtask

  task automatic t_tx();
    for (int i = 0; i < 16; i++) begin
      wr(6'h04, 16'(9'h100 + i * 3));
      peek(6'h14, v);
      if (i == 7) check("R3 half empty at 8", {15'd0, v[2]}, 16'd1);
      if (i == 8) check("R3 half empty clear at 9", {15'd0, v[2]}, 16'd0);
    end
    peek(6'h14, v);
    check("R2 tx full bit9", {15'd0, v[9]}, 16'd1);
    check("R3 tx not empty bit6 / empty bit1", {14'd0, v[6], v[1]}, 16'd2);
    wr(6'h04, 16'h0055);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R2 tx order", {7'd0, tx_data}, 16'(9'h100 + i * 3));
      tx_pop = 1'b1;
      @(negedge clk); tx_pop = 1'b0;
    end
    check("R2 tx dropped 17th", {15'd0, tx_avail}, 16'd0);
    peek(6'h14, v); check("R3 tx empty", {14'd0, v[6], v[1]}, 16'd1);
  endtask

  task automatic t_rx_overrun();
    for (int i = 0; i < 16; i++) begin
      push(pat(i));
      peek(6'h14, v);
      if (i == 6) check("R5 half full clear at 7", {15'd0, v[8]}, 16'd0);
      if (i == 7) check("R5 half full at 8", {15'd0, v[8]}, 16'd1);
    end
    peek(6'h14, v);
    check("R5 rx not empty", {15'd0, v[0]}, 16'd1);
    check("R4 head parity/frame bits", {14'd0, v[4], v[3]}, {14'd0, pat(0)[9], pat(0)[8]});
    check("R6 no overrun yet", {15'd0, v[5]}, 16'd0);
    push(10'h3FF);
    peek(6'h14, v); check("R6 overrun set", {15'd0, v[5]}, 16'd1);
    rd(6'h08, v); check("R4 rx read head", v, {6'd0, pat(0)});
    peek(6'h14, v); check("R6 overrun cleared by read", {15'd0, v[5]}, 16'd0);
    for (int i = 1; i < 16; i++) begin
      rd(6'h08, v); check("R4 rx order", v, {6'd0, pat(i)});
    end
    rd(6'h08, v); check("R6 overflow char discarded", v, 16'd0);
  endtask

  task automatic t_empty_read();
    rd(6'h08, v); check("R7 empty read zero", v, 16'd0);
    rd(6'h08, v); check("R7 empty read again", v, 16'd0);
    push(10'h1C3);
    rd(6'h08, v); check("R7 pointers intact", v, 16'h01C3);
    peek(6'h14, v); check("R7 empty after", {15'd0, v[0]}, 16'd0);
  endtask

  task automatic t_timeout();
    wr(6'h1C, 16'd3);
    wr(6'h10, 16'h0080);
    push(10'h011);
    tick(2);
    peek(6'h14, v); check("R8 not yet at limit", {15'd0, v[7]}, 16'd0);
    tick(1);
    peek(6'h14, v); check("R8 timeout at limit", {15'd0, v[7]}, 16'd1);
    check("R10 irq from timeout", {15'd0, irq}, 16'd1);
    rd(6'h08, v); check("R8 read data", v, 16'h0011);
    peek(6'h14, v); check("R8 cleared by read", {15'd0, v[7]}, 16'd0);
    push(10'h021);
    tick(2);
    push(10'h022);
    tick(2);
    peek(6'h14, v); check("R8 reload on new char", {15'd0, v[7]}, 16'd0);
    tick(1);
    peek(6'h14, v); check("R8 fires after reload", {15'd0, v[7]}, 16'd1);
    rd(6'h08, v); rd(6'h08, v);
    wr(6'h1C, 16'd0);
    push(10'h033);
    tick(5);
    peek(6'h14, v); check("R11 zero limit off", {15'd0, v[7]}, 16'd0);
    rd(6'h08, v);
    wr(6'h10, 16'h0000);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 3; i++) wr(6'h04, 16'(i + 1));
    wr(6'h20, 16'd1);
    peek(6'h14, v); check("R9 tx flush", {14'd0, v[6], v[1]}, 16'd1);
    check("R9 tx_avail after flush", {15'd0, tx_avail}, 16'd0);
    wr(6'h1C, 16'd1);
    for (int i = 0; i < 17; i++) push(pat(i));
    tick(1);
    peek(6'h14, v); check("R9 pre flush ovr+idle", {14'd0, v[7], v[5]}, 16'd3);
    wr(6'h24, 16'd1);
    peek(6'h14, v); check("R9 rx flush clears", {13'd0, v[7], v[5], v[0]}, 16'd0);
    rd(6'h08, v); check("R9 rx empty after flush", v, 16'd0);
  endtask

  task automatic t_irq();
    wr(6'h10, 16'h0002);
    peek(6'h10, v); check("R10 enable readback", v, 16'h0002);
    check("R10 irq tx empty enabled", {15'd0, irq}, 16'd1);
    wr(6'h10, 16'h0001);
    check("R10 irq masked", {15'd0, irq}, 16'd0);
    push(10'h0AA);
    check("R10 irq rx not empty", {15'd0, irq}, 16'd1);
    rd(6'h08, v);
    check("R10 irq drops", {15'd0, irq}, 16'd0);
    wr(6'h10, 16'h0000);
  endtask

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    tx_pop = 0; rx_push = 0; rx_word = '0; rx_tick = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_tx();
    t_rx_overrun();
    t_empty_read();
    t_timeout();
    t_flush();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule